// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Logic

This block sits beside the bit-level engine of an I2C master/slave controller and turns the engine's events into three status flags and one registered interrupt request. The flags are: transmit data register empty, receive data register full, and slave address match. Software reads and writes of the status and data registers clear them. The block also works out when SCL must be stretched so that a receive byte cannot be overrun. In slave mode it decides which received bytes may raise the receive flag.

A small filter removes single-clock glitches from the SDA and SCL inputs before the engine sees them. When the controller is disabled, the interrupt request follows the baud-rate generator tick instead, so the block can act as a plain timer interrupt. The engine, the pin drivers and the register file lie outside this block. Their events and strobes come in as plain one-cycle pulses or levels. There is no streaming data path, so no pin uses a valid/ready handshake.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: With `flt_en` high, a pulse on `sda_in` or `scl_in` lasting one clock is absent from `sda_f`/`scl_f`, and a level held for five clocks reaches them. With `flt_en` low, the lines pass through a two-flop synchronizer only, so a one-clock pulse does appear. Both outputs reset to 1.
- R2: The transmit-empty flag is `status[0]`. It sets on the clock edge after a cycle in which `tx_buf_empty` is high and at least one of these holds: `ev_addr10_first`; `ev_addr_last_first` with `rd_bit` low; or `ev_data_first`. With `rd_bit` high, `ev_addr_last_first` alone does not set it.
- R3: A `dr_wr` pulse clears `status[0]` on the next edge, unless a set condition from R2 occurs in the same cycle. A set always wins over a clear, for every flag.
- R4: The receive-full flag is `status[1]`. It sets on the edge after an accepted `ev_rx_byte` and clears after `dr_rd`. A `dr_rd` in the same cycle as an accepted byte leaves it set.
- R5: `scl_hold` is high exactly while `rx_last_bit` is high and `status[1]` is set. It drops in the cycle after the flag clears.
- R6: In master mode (`slave_mode` low), every received byte is accepted. In slave mode with `irx_all` low, address bytes are never accepted. Data bytes are accepted only if the latest address byte matched. With `irx_all` high, every byte is accepted.
- R7: The address-match flag is `status[2]`. It sets when `slave_mode` is high, `ev_rx_byte` and `rx_is_addr` are high, and `rx_byte[7:1]` equals `own_addr`.
- R8: `st_rd` clears all three flags. Either `dr_rd` or `dr_wr` also clears `status[2]`.
- R9: With `ctl_en` high, `irq` on the next edge is the OR of `status & ie`, where `ie` bit n enables `status` bit n.
- R10: With `ctl_en` low, `irq` on the next edge equals `brg_tick`, and all flags are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| flt_en | input | 1 | Glitch filter enable |
| slave_mode | input | 1 | Controller is addressed as a slave |
| irx_all | input | 1 | Accept every received byte in slave mode |
| own_addr | input | 7 | Programmed slave address |
| ie | input | 3 | Interrupt enables, one per status bit |
| sda_in | input | 1 | Raw SDA from the pad |
| scl_in | input | 1 | Raw SCL from the pad |
| sda_f | output | 1 | Filtered SDA |
| scl_f | output | 1 | Filtered SCL |
| tx_buf_empty | input | 1 | Transmit data register holds no byte |
| ev_addr10_first | input | 1 | First bit of a 10-bit address is shifting out |
| ev_addr_last_first | input | 1 | First bit of the final address byte is shifting out |
| rd_bit | input | 1 | Direction bit of the current transfer is read |
| ev_data_first | input | 1 | First bit of a data byte is shifting out |
| ev_rx_byte | input | 1 | A byte has been received |
| rx_is_addr | input | 1 | The received byte is an address byte |
| rx_byte | input | 8 | The received byte |
| rx_last_bit | input | 1 | Engine is on the final data bit of a receive byte |
| dr_wr | input | 1 | Software write to the data register |
| dr_rd | input | 1 | Software read of the data register |
| st_rd | input | 1 | Software read of the status register |
| brg_tick | input | 1 | Baud-rate generator tick |
| status | output | 3 | Flags: bit0 transmit empty, bit1 receive full, bit2 address match |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | Registered combined interrupt request |

## Verification
Two functions can fall in the same cycle: a software clear and a new flag-setting event. The bench provokes this in two ways. It pulses `dr_rd` together with `ev_rx_byte`, and it pulses `dr_wr` together with `ev_data_first` while `tx_buf_empty` is high. In both cases the flag must still read set on the next edge. A second overlap is the receive flag and an incoming final bit. The bench holds `rx_last_bit` while the flag is set and checks that `scl_hold` stays up. It then checks that the hold drops only in the cycle after a `dr_rd` clears the flag.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NFLAG  = 3;
  localparam int F_TDRE = 0;
  localparam int F_RDRF = 1;
  localparam int F_SAM  = 2;
  localparam int NLINE  = 2;
  localparam int L_SDA  = 0;
  localparam int L_SCL  = 1;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/i2c_glitch_flt.sv
module i2c_glitch_flt #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_en,
  input  logic din,
  output logic dout
);
  localparam int SW = SYNC_STAGES;

  logic [SW-1:0] sync_q;
  logic          prev_q;
  logic          out_q;
  logic          synced;

  assign synced = sync_q[SW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SW-2:0], din};
      prev_q <= synced;
      if (!flt_en)
        out_q <= synced;
      else if (synced == prev_q)
        out_q <= synced;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/i2c_flag_unit.sv
module i2c_flag_unit
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              slave_mode,
  input  logic              irx_all,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_buf_empty,
  input  logic              ev_addr10_first,
  input  logic              ev_addr_last_first,
  input  logic              rd_bit,
  input  logic              ev_data_first,
  input  logic              ev_rx_byte,
  input  logic              rx_is_addr,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic              dr_wr,
  input  logic              dr_rd,
  input  logic              st_rd,
  output flag_vec_t         flags
);
  flag_vec_t set_v, clr_v, flag_q;
  logic      addr_ok_q;
  logic      addr_hit;
  logic      rx_accept;
  logic      tx_milestone;

  assign addr_hit     = (rx_byte[ADDR_W:1] == own_addr);
  assign tx_milestone = ev_addr10_first | (ev_addr_last_first & ~rd_bit) | ev_data_first;

  always_comb begin
    if (!slave_mode || irx_all) rx_accept = 1'b1;
    else if (rx_is_addr)        rx_accept = 1'b0;
    else                        rx_accept = addr_ok_q;
  end

  always_comb begin
    set_v         = '0;
    set_v[F_TDRE] = tx_buf_empty & tx_milestone;
    set_v[F_RDRF] = ev_rx_byte & rx_accept;
    set_v[F_SAM]  = slave_mode & ev_rx_byte & rx_is_addr & addr_hit;
    clr_v         = '0;
    clr_v[F_TDRE] = st_rd | dr_wr;
    clr_v[F_RDRF] = st_rd | dr_rd;
    clr_v[F_SAM]  = st_rd | dr_rd | dr_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_ok_q <= 1'b0;
    else if (!ctl_en)
      addr_ok_q <= 1'b0;
    else if (slave_mode && ev_rx_byte && rx_is_addr)
      addr_ok_q <= addr_hit;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b0;
      else if (!ctl_en)    flag_q[g] <= 1'b0;
      else if (set_v[g])   flag_q[g] <= 1'b1;
      else if (clr_v[g])   flag_q[g] <= 1'b0;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/i2c_irq_merge.sv
module i2c_irq_merge
  import i2c_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_en,
  input  flag_vec_t flags,
  input  flag_vec_t ie,
  input  logic      brg_tick,
  input  logic      rx_last_bit,
  output logic      scl_hold,
  output logic      irq
);
  logic irq_d, irq_q;

  assign irq_d = ctl_en ? |(flags & ie) : brg_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq      = irq_q;
  assign scl_hold = rx_last_bit & flags[F_RDRF];
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              flt_en,
  input  logic              slave_mode,
  input  logic              irx_all,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [NFLAG-1:0]  ie,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_f,
  output logic              scl_f,
  input  logic              tx_buf_empty,
  input  logic              ev_addr10_first,
  input  logic              ev_addr_last_first,
  input  logic              rd_bit,
  input  logic              ev_data_first,
  input  logic              ev_rx_byte,
  input  logic              rx_is_addr,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic              rx_last_bit,
  input  logic              dr_wr,
  input  logic              dr_rd,
  input  logic              st_rd,
  input  logic              brg_tick,
  output logic [NFLAG-1:0]  status,
  output logic              scl_hold,
  output logic              irq
);
  logic [NLINE-1:0] line_raw, line_flt;
  flag_vec_t        flags;

  assign line_raw[L_SDA] = sda_in;
  assign line_raw[L_SCL] = scl_in;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    i2c_glitch_flt #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
      .clk(clk), .rst_n(rst_n), .flt_en(flt_en),
      .din(line_raw[l]), .dout(line_flt[l])
    );
  end

  assign sda_f = line_flt[L_SDA];
  assign scl_f = line_flt[L_SCL];

  i2c_flag_unit #(.ADDR_W(ADDR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
    .slave_mode(slave_mode), .irx_all(irx_all), .own_addr(own_addr),
    .tx_buf_empty(tx_buf_empty), .ev_addr10_first(ev_addr10_first),
    .ev_addr_last_first(ev_addr_last_first), .rd_bit(rd_bit),
    .ev_data_first(ev_data_first), .ev_rx_byte(ev_rx_byte),
    .rx_is_addr(rx_is_addr), .rx_byte(rx_byte),
    .dr_wr(dr_wr), .dr_rd(dr_rd), .st_rd(st_rd), .flags(flags)
  );

  i2c_irq_merge u_merge (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .flags(flags), .ie(ie),
    .brg_tick(brg_tick), .rx_last_bit(rx_last_bit),
    .scl_hold(scl_hold), .irq(irq)
  );

  assign status = flags;
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk #(
  parameter int ADDR_W = 7,
  parameter int NF     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic             slave_mode,
  input logic             ev_addr10_first,
  input logic             ev_addr_last_first,
  input logic             ev_data_first,
  input logic             ev_rx_byte,
  input logic             rx_is_addr,
  input logic             rx_last_bit,
  input logic             dr_wr,
  input logic             st_rd,
  input logic             brg_tick,
  input logic [NF-1:0]    ie,
  input logic [NF-1:0]    status,
  input logic             scl_hold,
  input logic             irq
);
  p_wr_clears_tdre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr && !ev_addr10_first && !ev_addr_last_first && !ev_data_first |=> !status[0]);

  p_rdrf_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(ev_rx_byte));

  p_hold_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> (status[1] && rx_last_bit));

  p_sam_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(slave_mode && ev_rx_byte && rx_is_addr));

  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd && !ev_rx_byte && !ev_addr10_first && !ev_addr_last_first && !ev_data_first
    |=> status == '0);

  p_irq_combine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en |=> irq == |($past(status & ie)));

  p_timer_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> irq == $past(brg_tick));

  p_disabled_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> status == '0);
endmodule

bind i2c_irq_ctrl i2c_irq_chk #(.ADDR_W(ADDR_W), .NF(i2c_irq_pkg::NFLAG)) u_chk (.*);

// File: tb/i2c_irq_ctrl_test.sv
`timescale 1ns/1ps
module i2c_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_en = 0, flt_en = 0, slave_mode = 0, irx_all = 0;
  logic [6:0] own_addr = 7'h2A;
  logic [2:0] ie = 3'b000;
  logic sda_in = 1, scl_in = 1;
  logic sda_f, scl_f;
  logic tx_buf_empty = 0, ev_addr10_first = 0, ev_addr_last_first = 0, rd_bit = 0;
  logic ev_data_first = 0, ev_rx_byte = 0, rx_is_addr = 0, rx_last_bit = 0;
  logic [7:0] rx_byte = 8'h00;
  logic dr_wr = 0, dr_rd = 0, st_rd = 0, brg_tick = 0;
  logic [2:0] status;
  logic scl_hold, irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  i2c_irq_ctrl uut (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet();
    ev_addr10_first = 0; ev_addr_last_first = 0; ev_data_first = 0;
    ev_rx_byte = 0; rx_is_addr = 0; dr_wr = 0; dr_rd = 0; st_rd = 0; brg_tick = 0;
  endtask

  task automatic clear_all();
    st_rd = 1; cyc(1); quiet(); cyc(1);
  endtask

  task automatic rx(input logic is_addr, input logic [7:0] b);
    ev_rx_byte = 1; rx_is_addr = is_addr; rx_byte = b; cyc(1); quiet();
  endtask

  task automatic t_reset();
    chk("R1 reset sda_f", sda_f, 1);
    chk("R1 reset scl_f", scl_f, 1);
    chk("R10 reset status", status, 0);
    chk("R9 reset irq", irq, 0);
    chk("R5 reset scl_hold", scl_hold, 0);
  endtask

  task automatic t_filter();
    logic lo;
    flt_en = 1; lo = 0;
    sda_in = 0; cyc(1); sda_in = 1;
    for (int i = 0; i < 6; i++) begin cyc(1); if (sda_f == 0) lo = 1; end
    chk("R1 filtered glitch sda", lo, 0);
    lo = 0; scl_in = 0; cyc(1); scl_in = 1;
    for (int i = 0; i < 6; i++) begin cyc(1); if (scl_f == 0) lo = 1; end
    chk("R1 filtered glitch scl", lo, 0);
    sda_in = 0; cyc(5);
    chk("R1 held level passes", sda_f, 0);
    sda_in = 1; cyc(5);
    flt_en = 0; lo = 0;
    sda_in = 0; cyc(1); sda_in = 1;
    for (int i = 0; i < 6; i++) begin cyc(1); if (sda_f == 0) lo = 1; end
    chk("R1 unfiltered pulse seen", lo, 1);
  endtask

  task automatic t_tdre();
    tx_buf_empty = 1;
    ev_addr10_first = 1; cyc(1); quiet();
    chk("R2 10-bit addr first bit", status[0], 1);
    dr_wr = 1; cyc(1); quiet();
    chk("R3 data write clears tdre", status[0], 0);
    rd_bit = 1; ev_addr_last_first = 1; cyc(1); quiet();
    chk("R2 final addr byte with read bit", status[0], 0);
    rd_bit = 0; ev_addr_last_first = 1; cyc(1); quiet();
    chk("R2 final addr byte write dir", status[0], 1);
    dr_wr = 1; cyc(1); quiet();
    tx_buf_empty = 0; ev_data_first = 1; cyc(1); quiet();
    chk("R2 data first bit but buffer full", status[0], 0);
    tx_buf_empty = 1; ev_data_first = 1; dr_wr = 1; cyc(1); quiet();
    chk("R3 set wins over write clear", status[0], 1);
    clear_all(); tx_buf_empty = 0;
  endtask

  task automatic t_rdrf();
    slave_mode = 0;
    rx(0, 8'h11);
    chk("R4 byte sets rdrf", status[1], 1);
    dr_rd = 1; cyc(1); quiet();
    chk("R4 data read clears rdrf", status[1], 0);
    rx(0, 8'h12);
    dr_rd = 1; ev_rx_byte = 1; rx_byte = 8'h13; cyc(1); quiet();
    chk("R4 new byte wins over read", status[1], 1);
    rx_last_bit = 1; #1;
    chk("R5 hold while rdrf set", scl_hold, 1);
    cyc(2);
    chk("R5 hold persists", scl_hold, 1);
    dr_rd = 1; cyc(1); quiet();
    chk("R5 hold drops after read", scl_hold, 0);
    rx_last_bit = 0;
    clear_all();
  endtask

  task automatic t_slave();
    slave_mode = 1; irx_all = 0;
    rx(1, 8'h54);
    chk("R7 matching address sets sam", status[2], 1);
    chk("R6 address byte not accepted", status[1], 0);
    dr_rd = 1; cyc(1); quiet();
    chk("R8 data read clears sam", status[2], 0);
    rx(0, 8'hA5);
    chk("R6 data after match accepted", status[1], 1);
    clear_all();
    rx(1, 8'h60);
    chk("R7 other address no sam", status[2], 0);
    rx(0, 8'hA6);
    chk("R6 data after mismatch ignored", status[1], 0);
    irx_all = 1;
    rx(1, 8'h60);
    chk("R6 interactive mode accepts address", status[1], 1);
    clear_all();
    irx_all = 0; slave_mode = 0;
    rx(1, 8'h54);
    chk("R7 no sam in master mode", status[2], 0);
    clear_all();
  endtask

  task automatic t_clear();
    slave_mode = 1; tx_buf_empty = 1;
    ev_data_first = 1; cyc(1); quiet();
    rx(1, 8'h54);
    rx(0, 8'h01);
    chk("R8 all flags set before status read", status, 3'b111);
    st_rd = 1; cyc(1); quiet();
    chk("R8 status read clears all", status, 0);
    rx(1, 8'h54);
    dr_wr = 1; cyc(1); quiet();
    chk("R8 data write clears sam", status[2], 0);
    slave_mode = 0; tx_buf_empty = 0; clear_all();
  endtask

  task automatic t_irq();
    ie = 3'b010;
    rx(0, 8'h22);
    chk("R9 irq lags flag by one cycle", irq, 0);
    cyc(1);
    chk("R9 enabled flag raises irq", irq, 1);
    ie = 3'b101; cyc(1);
    chk("R9 disabled source no irq", irq, 0);
    clear_all(); ie = 3'b000;
  endtask

  task automatic t_timer();
    rx(0, 8'h33);
    ctl_en = 0; cyc(1);
    chk("R10 flags cleared when disabled", status, 0);
    brg_tick = 1; cyc(1); brg_tick = 0;
    chk("R10 tick drives irq", irq, 1);
    cyc(1);
    chk("R10 irq follows tick low", irq, 0);
    ctl_en = 1; cyc(1);
  endtask

  initial begin
    cyc(2);
    t_reset();
    rst_n = 1; ctl_en = 1; cyc(1);
    t_filter();
    t_tdre();
    t_rdrf();
    t_slave();
    t_clear();
    t_irq();
    t_timer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule